// File: doc/BRIEF.md
# Remote-Line DRAM Cache Controller

This controller sits on the miss path of a GPU node's on-chip last-level cache. Every request that reaches it has already missed on chip. The controller reads the home node of the address from its top bits. Requests whose home is this node go straight to the local memory port and are never cached. Requests whose home is another node are looked up in a direct-mapped store. Each entry of the store holds a valid bit, a tag, the line payload and a 2-bit sharing state.

On a remote read miss, the controller sends one fetch over the remote-link port and stalls further requests. When the fill arrives, it installs the line together with the sharing state delivered with the data, and answers the requester. Writes are write-through and never allocate. A write updates a cached copy if one is present, and it is always forwarded to the home node. Two commands act on the stored entries. A flush at a synchronization boundary drops every entry at once. An invalidate drops the single entry whose tag matches.

Top module: `rdc_top`

## Requirements
- R1: After reset, req_ready_o is 1, loc_valid_o, rmt_valid_o and rsp_valid_o are 0, and every entry is invalid, so the first read of any remote line misses.
- R2: An accepted request whose home node equals local_node_i appears on the local port one cycle later, with the same address, write flag, data and ID. It causes no remote traffic, no response and no allocation.
- R3: An accepted remote read miss drives, one cycle later, a single read on the remote port (rmt_write_o=0) with the request address. req_ready_o then stays 0 until a fill arrives. One cycle after fill_valid_i, rsp_valid_o is 1 with rsp_hit_o=0, the fill data and the requester ID, and req_ready_o is 1 again.
- R4: An accepted remote read that hits responds one cycle later with rsp_hit_o=1, the stored data and the requester ID, and sends nothing on the remote port.
- R5: Every accepted remote write is forwarded one cycle later on the remote port with rmt_write_o=1, the address and the data. If the line is cached, its copy takes the new data. If it is not cached, nothing is allocated.
- R6: The 2-bit sharing state given with a fill is stored in the entry. It is returned on rsp_share_o, both in the miss response and in every later hit on that line.
- R7: While flush_i is 1, req_ready_o is 0. One cycle later, every entry is invalid.
- R8: An invalidate whose address matches the tag of a valid entry clears that entry. An invalidate with a different tag at the same index leaves the entry valid.
- R9: The store is direct-mapped. The index is address bits [7+IDX_W-1:7], and the tag is every bit above the index, home-node bits included. A second remote line with the same index and a different tag replaces the first.
- R10: Lines are 128 bytes. Addresses that differ only in bits [6:0] map to the same entry. The home node is address bits [ADDR_W-1:ADDR_W-NODE_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| local_node_i | input | NODE_W | ID of this node |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be accepted |
| req_addr_i | input | ADDR_W | Request byte address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | DATA_W | Write payload |
| req_id_i | input | ID_W | Requester ID |
| rsp_valid_o | output | 1 | Read response for a remote line |
| rsp_hit_o | output | 1 | Response served from the store |
| rsp_id_o | output | ID_W | Requester ID of the response |
| rsp_data_o | output | DATA_W | Response payload |
| rsp_share_o | output | 2 | Sharing state of the line |
| loc_valid_o | output | 1 | Request to local memory |
| loc_addr_o | output | ADDR_W | Local request address |
| loc_write_o | output | 1 | Local request is a write |
| loc_wdata_o | output | DATA_W | Local write payload |
| loc_id_o | output | ID_W | Local requester ID |
| rmt_valid_o | output | 1 | Request on the remote link |
| rmt_addr_o | output | ADDR_W | Remote request address |
| rmt_write_o | output | 1 | 1 = forwarded write, 0 = line fetch |
| rmt_wdata_o | output | DATA_W | Forwarded write payload |
| fill_valid_i | input | 1 | Fetched line arrives |
| fill_data_i | input | DATA_W | Fetched line payload |
| fill_share_i | input | 2 | Sharing state delivered with the line |
| flush_i | input | 1 | Invalidate every entry |
| inv_valid_i | input | 1 | Invalidate one line |
| inv_addr_i | input | ADDR_W | Address of the line to invalidate |

## Verification
The bench keeps its own model of the entries and targets several corner cases.

- An address that differs from a cached one only in its offset must hit. A design that keeps the offset in the tag would miss instead.
- A write to a line that is not cached must not allocate. A write-allocate design would make the next read hit.
- Two lines on the same index must evict each other. The same is true of two lines whose addresses differ only in the home-node bits, which a design that drops those bits from the tag would confuse.
- An invalidate whose tag does not match must leave the entry alone, while a flush must empty the whole store.
- During a pending miss the bench holds the fill back for several cycles, which exposes any design that raises ready early.
- Every hit is compared against the sharing state of the latest fill, so a design that loses the state or overwrites it on a write hit is reported.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  localparam int LINE_BYTES = 128;
  localparam int OFF_W      = $clog2(LINE_BYTES);

  typedef logic [1:0] share_t;
  typedef enum logic {ST_IDLE, ST_WAIT} rdc_state_e;
endpackage

// File: rtl/rdc_addr_split.sv
module rdc_addr_split
  import rdc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o
);
  logic unused_off;
  assign unused_off = ^addr_i[OFF_W-1:0];
  assign idx_o = addr_i[OFF_W +: IDX_W];
  assign tag_o = addr_i[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/rdc_line_store.sv
module rdc_line_store
  import rdc_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 21,
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  lk_idx_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  output logic              lk_hit_o,
  output logic [DATA_W-1:0] lk_data_o,
  output share_t            lk_share_o,
  input  logic              upd_en_i,
  input  logic [IDX_W-1:0]  upd_idx_i,
  input  logic [DATA_W-1:0] upd_data_i,
  input  logic              fill_en_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  share_t            fill_share_i,
  input  logic              inv_en_i,
  input  logic [IDX_W-1:0]  inv_idx_i,
  input  logic [TAG_W-1:0]  inv_tag_i,
  input  logic              flush_i
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [TAG_W-1:0]   tag_q   [ENTRIES];
  logic [DATA_W-1:0]  data_q  [ENTRIES];
  share_t             share_q [ENTRIES];
  logic               inv_hit;

  assign inv_hit    = inv_en_i & valid_q[inv_idx_i] & (tag_q[inv_idx_i] == inv_tag_i);
  assign lk_hit_o   = valid_q[lk_idx_i] & (tag_q[lk_idx_i] == lk_tag_i);
  assign lk_data_o  = data_q[lk_idx_i];
  assign lk_share_o = share_q[lk_idx_i];

  // fill wins over invalidate and flush in the same cycle
  always_comb begin
    valid_d = valid_q;
    if (flush_i)      valid_d = '0;
    else if (inv_hit) valid_d[inv_idx_i] = 1'b0;
    if (fill_en_i)    valid_d[fill_idx_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else         valid_q <= valid_d;
  end

  always_ff @(posedge clk_i) begin
    if (fill_en_i) begin
      tag_q[fill_idx_i]   <= fill_tag_i;
      data_q[fill_idx_i]  <= fill_data_i;
      share_q[fill_idx_i] <= fill_share_i;
    end else if (upd_en_i) begin
      data_q[upd_idx_i] <= upd_data_i;
    end
  end

  assert_flush_empties_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i && !fill_en_i |=> valid_q == '0);

  assert_fill_keeps_state_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en_i |=> valid_q[$past(fill_idx_i)] && share_q[$past(fill_idx_i)] == $past(fill_share_i));

  assert_inv_drops_entry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_hit && !(fill_en_i && fill_idx_i == inv_idx_i) |=> !valid_q[$past(inv_idx_i)]);
endmodule

// File: rtl/rdc_top.sv
module rdc_top
  import rdc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NODE_W = 2,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 64,
  parameter int ID_W   = 4,
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NODE_W-1:0] local_node_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [ID_W-1:0]   req_id_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [ID_W-1:0]   rsp_id_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic [1:0]        rsp_share_o,
  output logic              loc_valid_o,
  output logic [ADDR_W-1:0] loc_addr_o,
  output logic              loc_write_o,
  output logic [DATA_W-1:0] loc_wdata_o,
  output logic [ID_W-1:0]   loc_id_o,
  output logic              rmt_valid_o,
  output logic [ADDR_W-1:0] rmt_addr_o,
  output logic              rmt_write_o,
  output logic [DATA_W-1:0] rmt_wdata_o,
  input  logic              fill_valid_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic [1:0]        fill_share_i,
  input  logic              flush_i,
  input  logic              inv_valid_i,
  input  logic [ADDR_W-1:0] inv_addr_i
);
  rdc_state_e        st_q;
  logic [IDX_W-1:0]  req_idx, inv_idx, pend_idx_q;
  logic [TAG_W-1:0]  req_tag, inv_tag, pend_tag_q;
  logic [ID_W-1:0]   pend_id_q;
  logic              accept, is_remote, lk_hit, fill_en, upd_en;
  logic [DATA_W-1:0] lk_data;
  share_t            lk_share;

  rdc_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_req_split (
    .addr_i(req_addr_i), .idx_o(req_idx), .tag_o(req_tag));

  rdc_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_inv_split (
    .addr_i(inv_addr_i), .idx_o(inv_idx), .tag_o(inv_tag));

  assign req_ready_o = (st_q == ST_IDLE) & ~flush_i;
  assign accept      = req_valid_i & req_ready_o;
  assign is_remote   = req_addr_i[ADDR_W-1 -: NODE_W] != local_node_i;
  assign fill_en     = (st_q == ST_WAIT) & fill_valid_i;
  assign upd_en      = accept & is_remote & req_write_i & lk_hit;

  rdc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni,
    .lk_idx_i(req_idx), .lk_tag_i(req_tag),
    .lk_hit_o(lk_hit), .lk_data_o(lk_data), .lk_share_o(lk_share),
    .upd_en_i(upd_en), .upd_idx_i(req_idx), .upd_data_i(req_wdata_i),
    .fill_en_i(fill_en), .fill_idx_i(pend_idx_q), .fill_tag_i(pend_tag_q),
    .fill_data_i(fill_data_i), .fill_share_i(fill_share_i),
    .inv_en_i(inv_valid_i), .inv_idx_i(inv_idx), .inv_tag_i(inv_tag),
    .flush_i(flush_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      pend_idx_q  <= '0;
      pend_tag_q  <= '0;
      pend_id_q   <= '0;
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_id_o    <= '0;
      rsp_data_o  <= '0;
      rsp_share_o <= '0;
      loc_valid_o <= 1'b0;
      loc_addr_o  <= '0;
      loc_write_o <= 1'b0;
      loc_wdata_o <= '0;
      loc_id_o    <= '0;
      rmt_valid_o <= 1'b0;
      rmt_addr_o  <= '0;
      rmt_write_o <= 1'b0;
      rmt_wdata_o <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      loc_valid_o <= 1'b0;
      rmt_valid_o <= 1'b0;
      if (accept && !is_remote) begin
        loc_valid_o <= 1'b1;
        loc_addr_o  <= req_addr_i;
        loc_write_o <= req_write_i;
        loc_wdata_o <= req_wdata_i;
        loc_id_o    <= req_id_i;
      end else if (accept && req_write_i) begin
        rmt_valid_o <= 1'b1;
        rmt_addr_o  <= req_addr_i;
        rmt_write_o <= 1'b1;
        rmt_wdata_o <= req_wdata_i;
      end else if (accept && lk_hit) begin
        rsp_valid_o <= 1'b1;
        rsp_hit_o   <= 1'b1;
        rsp_id_o    <= req_id_i;
        rsp_data_o  <= lk_data;
        rsp_share_o <= lk_share;
      end else if (accept) begin
        rmt_valid_o <= 1'b1;
        rmt_addr_o  <= req_addr_i;
        rmt_write_o <= 1'b0;
        pend_idx_q  <= req_idx;
        pend_tag_q  <= req_tag;
        pend_id_q   <= req_id_i;
        st_q        <= ST_WAIT;
      end else if (fill_en) begin
        rsp_valid_o <= 1'b1;
        rsp_hit_o   <= 1'b0;
        rsp_id_o    <= pend_id_q;
        rsp_data_o  <= fill_data_i;
        rsp_share_o <= fill_share_i;
        st_q        <= ST_IDLE;
      end
    end
  end

  assert_local_bypass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !is_remote |=> loc_valid_o && !rmt_valid_o && !rsp_valid_o);

  assert_fetch_stalls_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rmt_valid_o && !rmt_write_o |-> !req_ready_o);

  assert_miss_rsp_after_fill_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_hit_o |-> $past(fill_valid_i));

  assert_hit_stays_local_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_hit_o |-> !rmt_valid_o);

  assert_write_forwarded_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && is_remote && req_write_i |=> rmt_valid_o && rmt_write_o);

  assert_single_outlet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({loc_valid_o, rmt_valid_o, rsp_valid_o}));
endmodule

// File: tb/rdc_top_test.sv
`timescale 1ns/1ps
module rdc_top_test;
  localparam int ADDR_W = 32, NODE_W = 2, IDX_W = 4, DATA_W = 64, ID_W = 4;
  localparam int ENT = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - 7 - IDX_W;
  localparam logic [1:0] LOCAL = 2'd1;

  logic clk = 0, rst_ni = 0;
  always #2 clk = ~clk;

  logic [NODE_W-1:0] local_node = LOCAL;
  logic req_valid = 0, req_write = 0, req_ready;
  logic [ADDR_W-1:0] req_addr = '0, inv_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0, fill_data = '0;
  logic [ID_W-1:0] req_id = '0;
  logic fill_valid = 0, flush = 0, inv_valid = 0;
  logic [1:0] fill_share = '0;
  logic rsp_valid, rsp_hit, loc_valid, loc_write, rmt_valid, rmt_write;
  logic [ID_W-1:0] rsp_id, loc_id;
  logic [DATA_W-1:0] rsp_data, loc_wdata, rmt_wdata;
  logic [1:0] rsp_share;
  logic [ADDR_W-1:0] loc_addr, rmt_addr;

  rdc_top #(.ADDR_W(ADDR_W), .NODE_W(NODE_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .ID_W(ID_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .local_node_i(local_node),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_write_i(req_write), .req_wdata_i(req_wdata), .req_id_i(req_id),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_id_o(rsp_id),
    .rsp_data_o(rsp_data), .rsp_share_o(rsp_share),
    .loc_valid_o(loc_valid), .loc_addr_o(loc_addr), .loc_write_o(loc_write),
    .loc_wdata_o(loc_wdata), .loc_id_o(loc_id),
    .rmt_valid_o(rmt_valid), .rmt_addr_o(rmt_addr), .rmt_write_o(rmt_write),
    .rmt_wdata_o(rmt_wdata),
    .fill_valid_i(fill_valid), .fill_data_i(fill_data), .fill_share_i(fill_share),
    .flush_i(flush), .inv_valid_i(inv_valid), .inv_addr_i(inv_addr));

  int vectors = 0, fails = 0;
  bit done = 0;

  logic             m_valid [ENT];
  logic [TAG_W-1:0] m_tag   [ENT];
  logic [DATA_W-1:0] m_data [ENT];
  logic [1:0]       m_share [ENT];

  function automatic logic [ADDR_W-1:0] mk(input logic [1:0] node, input logic [18:0] mid,
                                           input logic [3:0] idx, input logic [6:0] off);
    return {node, mid, idx, off};
  endfunction
  function automatic logic [3:0] f_idx(input logic [ADDR_W-1:0] a); return a[10:7]; endfunction
  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a); return a[31:11]; endfunction
  function automatic bit m_hit(input logic [ADDR_W-1:0] a);
    return m_valid[f_idx(a)] && m_tag[f_idx(a)] == f_tag(a);
  endfunction

  task automatic chk(input string r, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  // read: returns nothing; checks against model and updates it on a fill
  task automatic do_read(input logic [ADDR_W-1:0] a, input logic [ID_W-1:0] id, input int delay,
                         input logic [DATA_W-1:0] fd, input logic [1:0] fs);
    bit loc = (a[31:30] == LOCAL);
    bit hit = m_hit(a);
    @(negedge clk);
    chk("R3 ready before read", req_ready, 1);
    req_valid = 1; req_addr = a; req_write = 0; req_id = id;
    @(negedge clk);
    req_valid = 0;
    if (loc) begin
      chk("R2 local read valid", loc_valid, 1);
      chk("R2 local read addr", loc_addr, a);
      chk("R2 local read id", loc_id, id);
      chk("R2 local read no remote", {rmt_valid, rsp_valid}, 0);
    end else if (hit) begin
      chk("R4 hit rsp", {rsp_valid, rsp_hit, rmt_valid}, 3'b110);
      chk("R4 hit data", rsp_data, m_data[f_idx(a)]);
      chk("R4 hit id", rsp_id, id);
      chk("R6 hit share", rsp_share, m_share[f_idx(a)]);
    end else begin
      chk("R3 fetch issued", {rmt_valid, rmt_write, rsp_valid}, 3'b100);
      chk("R3 fetch addr", rmt_addr, a);
      chk("R3 ready low on miss", req_ready, 0);
      for (int i = 0; i < delay; i++) begin
        @(negedge clk);
        chk("R3 ready low while pending", req_ready, 0);
        chk("R3 single fetch", {rmt_valid, rsp_valid}, 0);
      end
      fill_valid = 1; fill_data = fd; fill_share = fs;
      @(negedge clk);
      fill_valid = 0;
      chk("R3 miss rsp", {rsp_valid, rsp_hit}, 2'b10);
      chk("R3 miss data", rsp_data, fd);
      chk("R3 miss id", rsp_id, id);
      chk("R6 miss share", rsp_share, fs);
      chk("R3 ready after fill", req_ready, 1);
      m_valid[f_idx(a)] = 1; m_tag[f_idx(a)] = f_tag(a);
      m_data[f_idx(a)] = fd; m_share[f_idx(a)] = fs;
    end
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [ID_W-1:0] id,
                          input logic [DATA_W-1:0] d);
    bit loc = (a[31:30] == LOCAL);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = 1; req_wdata = d; req_id = id;
    @(negedge clk);
    req_valid = 0;
    if (loc) begin
      chk("R2 local write", {loc_valid, loc_write, rmt_valid, rsp_valid}, 4'b1100);
      chk("R2 local write addr", loc_addr, a);
      chk("R2 local write data", loc_wdata, d);
      chk("R2 local write id", loc_id, id);
    end else begin
      chk("R5 write forwarded", {rmt_valid, rmt_write, rsp_valid, loc_valid}, 4'b1100);
      chk("R5 write addr", rmt_addr, a);
      chk("R5 write data", rmt_wdata, d);
      if (m_hit(a)) m_data[f_idx(a)] = d;
    end
  endtask

  task automatic do_inv(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    inv_valid = 1; inv_addr = a;
    @(negedge clk);
    inv_valid = 0;
    if (m_hit(a)) m_valid[f_idx(a)] = 0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1;
    #1 chk("R7 ready low during flush", req_ready, 0);
    @(negedge clk);
    flush = 0;
    for (int i = 0; i < ENT; i++) m_valid[i] = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [ADDR_W-1:0] a, b;
    void'($urandom(32'h5eed_c0de));
    for (int i = 0; i < ENT; i++) begin m_valid[i] = 0; m_tag[i] = '0; m_data[i] = '0; m_share[i] = '0; end
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1
    chk("R1 reset ready", req_ready, 1);
    chk("R1 reset outputs idle", {loc_valid, rmt_valid, rsp_valid}, 0);
    for (int i = 0; i < ENT; i++)
      do_read(mk(2'd2, 19'h10, i[3:0], 7'd0), 4'h1, 0, 64'hA000 + i, 2'(i));
    do_flush();
    // R10 line granularity: offset change hits
    a = mk(2'd0, 19'h123, 4'd5, 7'h00);
    do_read(a, 4'h2, 2, 64'hDEAD_BEEF_0000_0001, 2'd3);
    do_read(a | 7'h7F, 4'h3, 0, 0, 0);
    chk("R10 offset stays on line", m_hit(a | 7'h7F), 1);
    // R10 home node: same low bits with local node goes local
    do_read({LOCAL, a[29:0]}, 4'h4, 0, 0, 0);
    // R5 write hit updates, share kept (R6)
    do_write(a, 4'h5, 64'h1111_2222_3333_4444);
    do_read(a, 4'h6, 0, 0, 0);
    // R5 write miss does not allocate
    b = mk(2'd3, 19'h7, 4'd9, 7'h10);
    do_write(b, 4'h7, 64'h55);
    do_read(b, 4'h8, 1, 64'h99, 2'd1);
    // R9 conflict: same index other tag, and other home node only
    b = mk(2'd0, 19'h124, 4'd5, 7'h0);
    do_read(b, 4'h9, 0, 64'hB0B0, 2'd2);
    do_read(a, 4'hA, 0, 64'hA0A0, 2'd0);
    do_read({2'd2, a[29:0]}, 4'hB, 0, 64'hC0C0, 2'd1);
    do_read(a, 4'hC, 0, 64'hD0D0, 2'd3);
    // R8 invalidate: other tag ignored, matching tag clears
    do_inv(b);
    do_read(a, 4'hD, 0, 0, 0);
    do_inv(a);
    do_read(a, 4'hE, 3, 64'hE0E0, 2'd2);
    // R7 flush then miss
    do_flush();
    do_read(a, 4'hF, 0, 64'hF0F0, 2'd1);
    // random mix
    for (int n = 0; n < 500; n++) begin
      int op = $urandom_range(0, 19);
      logic [ADDR_W-1:0] r = mk(2'($urandom_range(0, 3)), 19'($urandom_range(0, 2)),
                                4'($urandom_range(0, 3)), 7'($urandom));
      if (op < 9)       do_read(r, 4'($urandom), $urandom_range(0, 3), {$urandom, $urandom}, 2'($urandom));
      else if (op < 16) do_write(r, 4'($urandom), {$urandom, $urandom});
      else if (op < 19) do_inv(r);
      else              do_flush();
    end
    repeat (2) @(negedge clk);
    summary();
  end
endmodule